// File: doc/BRIEF.md
# Aging Counter Page Selector

This block tracks how recently each of a fixed set of memory pages has been used. It does not do the exact least-recently-used bookkeeping. Instead it keeps a short shift history per page and reports the page whose history shows the least recent use, so that a replacement engine can evict it. Each page owns a referenced flag and an age register. A reference strobe with a page index sets that page's flag. A periodic tick pulse shifts every age register one place toward the least significant end, puts the page's flag into the vacated top bit and starts a new interval with all flags cleared.

The design is approximate on purpose. It cannot tell which of several references came first inside one interval. It also forgets any use older than the width of the age register. In exchange, one tick updates every page at once, and only a plain magnitude comparison is needed to pick the victim. The victim index is combinational from the age registers. All age registers are also presented on a packed read-back bus.

Top module: `aging_page_selector`

## Requirements
- R1: After reset (asynchronous, active low) every age register and every referenced flag is zero and `victim_o` is 0.
- R2: On a cycle with `tick_i` high, each page's age becomes {flag, age[W-1:1]}. On any other cycle every age register keeps its value.
- R3: Every referenced flag clears at a tick. A page that is referenced before one tick and not again gets a top bit of 0 at the following tick.
- R4: `victim_o` names a page whose age value is the smallest of all pages.
- R5: When several pages share the smallest age, `victim_o` gives the lowest page index among them.
- R6: A reference presented in the same cycle as a tick is not sampled by that tick. It counts toward the next interval.
- R7: Several references to one page within a single interval have the same effect as one reference.
- R8: A single reference falls out of the history after W ticks. With W=8, the page reads 8'h01 after 8 ticks and 8'h00 after 9 ticks.
- R9: A reference whose page index is not less than the page count changes no flag and no age.
- R10: `ages_o` carries page i's age register in bits [i*W +: W].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_valid_i | input | 1 | Reference strobe |
| ref_page_i | input | IDX_W | Page index of the reference |
| tick_i | input | 1 | Aging tick pulse |
| victim_o | output | IDX_W | Index of the page with the smallest age |
| ages_o | output | NUM_PAGES*AGE_W | Packed age registers, page 0 in the low bits |

## Verification
Some behaviours are checked by the assertions on every cycle:
- the shift-with-flag update on a tick, and that the ages hold between ticks;
- that flags clear at a tick and only accumulate between ticks;
- that out-of-range references are ignored;
- that the victim has the minimum age and wins ties by the lowest index.

Other behaviours only the bench scenarios can show, because they depend on a history over many ticks:
- the full multi-tick aging sequence against known counter values;
- the loss of a reference after eight shifts;
- a reference that lands on the tick edge being deferred to the next interval.

// File: rtl/aging_sel_pkg.sv
package aging_sel_pkg;
  localparam int unsigned DEF_PAGES = 6;
  localparam int unsigned DEF_AGE_W = 8;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/aging_ref_bits.sv
module aging_ref_bits #(
  parameter int unsigned NUM_PAGES = 6,
  parameter int unsigned IDX_W     = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ref_valid_i,
  input  logic [IDX_W-1:0]     ref_page_i,
  input  logic                 tick_i,
  output logic [NUM_PAGES-1:0] ref_bits_o
);
  logic [NUM_PAGES-1:0] hit;

  for (genvar i = 0; i < NUM_PAGES; i++) begin : g_hit
    assign hit[i] = ref_valid_i && (ref_page_i == IDX_W'(i));
  end

  // A reference coincident with a tick seeds the new interval
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ref_bits_o <= '0;
    else if (tick_i) ref_bits_o <= hit;
    else             ref_bits_o <= ref_bits_o | hit;
  end

  p_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && !ref_valid_i |=> ref_bits_o == '0);

  p_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> (ref_bits_o & $past(ref_bits_o)) == $past(ref_bits_o));

  p_range_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_valid_i && ({1'b0, ref_page_i} >= (IDX_W+1)'(NUM_PAGES)) && !tick_i
    |=> $stable(ref_bits_o));
endmodule

// File: rtl/aging_age_bank.sv
module aging_age_bank #(
  parameter int unsigned NUM_PAGES = 6,
  parameter int unsigned AGE_W     = 8
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             tick_i,
  input  logic [NUM_PAGES-1:0]             ref_bits_i,
  output logic [NUM_PAGES-1:0][AGE_W-1:0]  ages_o
);
  for (genvar i = 0; i < NUM_PAGES; i++) begin : g_page
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     ages_o[i] <= '0;
      else if (tick_i) ages_o[i] <= {ref_bits_i[i], ages_o[i][AGE_W-1:1]};
    end

    p_shift_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_i |=> ages_o[i] == {$past(ref_bits_i[i]), $past(ages_o[i][AGE_W-1:1])});

    p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !tick_i |=> $stable(ages_o[i]));
  end
endmodule

// File: rtl/aging_min_pick.sv
module aging_min_pick #(
  parameter int unsigned NUM_PAGES = 6,
  parameter int unsigned AGE_W     = 8,
  parameter int unsigned IDX_W     = 3
) (
  input  logic [NUM_PAGES-1:0][AGE_W-1:0] ages_i,
  output logic [IDX_W-1:0]                victim_o
);
  logic [AGE_W-1:0] best_val;

  // Strict less-than keeps the lowest index on ties
  always_comb begin
    best_val = ages_i[0];
    victim_o = '0;
    for (int i = 1; i < NUM_PAGES; i++) begin
      if (ages_i[i] < best_val) begin
        best_val = ages_i[i];
        victim_o = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/aging_page_selector.sv
module aging_page_selector
  import aging_sel_pkg::*;
#(
  parameter int unsigned NUM_PAGES = DEF_PAGES,
  parameter int unsigned AGE_W     = DEF_AGE_W,
  localparam int unsigned IDX_W    = idx_width(NUM_PAGES),
  localparam int unsigned BUS_W    = NUM_PAGES * AGE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_valid_i,
  input  logic [IDX_W-1:0] ref_page_i,
  input  logic             tick_i,
  output logic [IDX_W-1:0] victim_o,
  output logic [BUS_W-1:0] ages_o
);
  logic [NUM_PAGES-1:0]            ref_bits;
  logic [NUM_PAGES-1:0][AGE_W-1:0] ages;

  aging_ref_bits #(.NUM_PAGES(NUM_PAGES), .IDX_W(IDX_W)) u_ref (
    .clk_i, .rst_ni, .ref_valid_i, .ref_page_i, .tick_i,
    .ref_bits_o(ref_bits)
  );

  aging_age_bank #(.NUM_PAGES(NUM_PAGES), .AGE_W(AGE_W)) u_bank (
    .clk_i, .rst_ni, .tick_i,
    .ref_bits_i(ref_bits),
    .ages_o(ages)
  );

  aging_min_pick #(.NUM_PAGES(NUM_PAGES), .AGE_W(AGE_W), .IDX_W(IDX_W)) u_pick (
    .ages_i(ages),
    .victim_o(victim_o)
  );

  assign ages_o = ages;

  for (genvar i = 0; i < NUM_PAGES; i++) begin : g_chk
    p_min_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ages[victim_o] <= ages[i]);

    p_tie_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ages[victim_o] == ages[i] |-> victim_o <= IDX_W'(i));
  end
endmodule

// File: tb/aging_page_selector_tb.sv
`timescale 1ns/1ps
module aging_page_selector_tb;
  localparam int N = 6;
  localparam int W = 8;
  localparam int IW = 3;
  localparam int ROWS = 5;

  // Flag pattern bit i = page i; expected ages packed {p5..p0}
  localparam logic [N-1:0]   PAT [ROWS] = '{6'b110101, 6'b010011, 6'b101011, 6'b010001, 6'b000110};
  localparam logic [N*W-1:0] EXP [ROWS] = '{48'h8080_0080_0080, 48'h40C0_0040_80C0,
                                            48'hA060_8020_C0E0, 48'h50B0_4010_60F0,
                                            48'h2858_2088_B078};
  localparam logic [IW-1:0]  VIC [ROWS] = '{3'd1, 3'd3, 3'd2, 3'd2, 3'd3};

  logic clk = 0, rst_n = 0, ref_valid = 0, tick = 0;
  logic [IW-1:0] ref_page = '0;
  logic [IW-1:0] victim;
  logic [N*W-1:0] ages;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  aging_page_selector u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ref_valid_i(ref_valid), .ref_page_i(ref_page),
    .tick_i(tick), .victim_o(victim), .ages_o(ages)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; ref_valid = 0; tick = 0;
    @(negedge clk); rst_n = 1;
  endtask

  task automatic do_ref(input int p);
    ref_valid = 1; ref_page = IW'(p);
    @(negedge clk); ref_valid = 0;
  endtask

  task automatic do_tick();
    tick = 1;
    @(negedge clk); tick = 0;
  endtask

  function automatic logic [W-1:0] age_of(input int p);
    return ages[p*W +: W];
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset ages", ages, '0);
    check("R1 reset victim", victim, 0);
    rst_n = 1;
    @(negedge clk);

    // Table walk: R2, R4, R10 (odd pages referenced twice: R7)
    for (int r = 0; r < ROWS; r++) begin
      for (int p = 0; p < N; p++) begin
        if (PAT[r][p]) begin
          do_ref(p);
          if (p % 2 == 1) do_ref(p);
        end
      end
      do_tick();
      for (int p = 0; p < N; p++) check("R2/R10 table age", age_of(p), EXP[r][p*W +: W]);
      check("R4 table victim", victim, VIC[r]);
    end
    // R2 hold: no tick, ages unchanged
    repeat (3) @(negedge clk);
    check("R2 hold without tick", ages, EXP[ROWS-1]);

    // R1 reset mid-run
    do_reset();
    check("R1 reset after run", ages, '0);
    check("R1 victim after run", victim, 0);

    // R5: all equal -> page 0; pages 0,1 referenced -> page 2
    check("R5 tie all zero", victim, 0);
    do_ref(0); do_ref(1); do_tick();
    check("R5 tie lowest index", victim, 2);

    // R3: flag clears after a tick
    do_reset();
    do_ref(1); do_tick();
    check("R3 first tick", age_of(1), 8'h80);
    do_tick();
    check("R3 flag cleared", age_of(1), 8'h40);

    // R6: reference on the tick edge goes to the next interval
    do_reset();
    ref_valid = 1; ref_page = 3'd4; tick = 1;
    @(negedge clk); ref_valid = 0; tick = 0;
    check("R6 not sampled by coincident tick", age_of(4), 8'h00);
    do_tick();
    check("R6 counted at next tick", age_of(4), 8'h80);

    // R7: repeated references equal one
    do_reset();
    do_ref(0); do_ref(0); do_ref(0); do_ref(5); do_tick();
    check("R7 repeated refs page0", age_of(0), 8'h80);
    check("R7 single ref page5", age_of(5), 8'h80);

    // R8: history fades after W ticks
    do_reset();
    do_ref(2);
    for (int t = 0; t < 8; t++) do_tick();
    check("R8 after 8 ticks", age_of(2), 8'h01);
    do_tick();
    check("R8 after 9 ticks", age_of(2), 8'h00);

    // R9: out-of-range indices ignored
    do_reset();
    do_ref(6); do_ref(7); do_tick();
    check("R9 out-of-range ages", ages, '0);
    check("R9 out-of-range victim", victim, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R1 watchdog: actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule